// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block generates the raster timing for a parallel RGB display panel that is clocked by a pixel clock. It drives horizontal sync, vertical sync and a data-enable pin. It also drives an active-high pixel-request strobe, which tells an upstream fetch path when to present a pixel. A one-cycle frame-start pulse marks the first clock of every frame, so that the caller can swap display buffers at the vertical sync leading edge. The block does not fetch pixel data, does not buffer it and does not generate the pixel clock. It produces timing only.

Software programs the geometry through plain configuration inputs:
- The line length and the HSYNC width, in pixel clocks.
- A horizontal wait and a valid-pixel count. The wait is measured from the HSYNC leading edge and includes the sync width.
- The frame length and the VSYNC width.
- A vertical wait and a valid-line count. The wait is measured from the VSYNC leading edge, in lines.
- Four polarity controls: HSYNC, VSYNC and DE each select active-high or active-low, and the clock-edge control selects the rising or the falling edge.
- A unit bit. When it is set, the VSYNC width and the frame length count whole lines. When it is clear, they count pixel clocks.

Software raises the sync enable before it starts the run. While the run input is low, all counters stay at zero and every output sits at its inactive level.

The pixel strobe has no ready input. Panel timing cannot stall, so the consumer must accept a pixel in every cycle the strobe is high; back-pressure is not possible.

Top module: `dtg_top`

## Requirements
- R1: While `enable_i` is high, the horizontal position advances by one each clock and wraps to 0 after `h_period_i` clocks. All outputs are registered and reflect the counter state of the previous clock.
- R2: `hsync_o` is active for horizontal positions 0 to `h_sync_w_i`-1 of every line.
- R3: `de_o` is active for horizontal positions `h_wait_i` to `h_wait_i`+`h_valid_i`-1, and only on active lines.
- R4: A line is active when its index within the frame lies in `v_wait_i` to `v_wait_i`+`v_valid_i`-1. A wait of 0 starts active data on the first clock of the frame.
- R5: `pix_req_o` is high exactly when DE is active, whatever the DE polarity, and the consumer cannot back-pressure it.
- R6: With `v_unit_lines_i`=1, a frame lasts `v_period_i` lines and `vsync_o` is active during its first `v_sync_w_i` lines.
- R7: With `v_unit_lines_i`=0, a frame lasts `v_period_i` pixel clocks and `vsync_o` is active during its first `v_sync_w_i` clocks. The line counter restarts at the frame end, even if that falls mid-line.
- R8: `hs_high_i`, `vs_high_i` and `de_high_i` each make their pin active-high when 1 and active-low when 0. `dclk_fall_o` is 1 while running when `clk_fall_i`=1, and 0 otherwise.
- R9: With `sync_en_i`=0, `hsync_o` and `vsync_o` hold their inactive level while DE timing continues.
- R10: `frame_start_o` is a one-cycle pulse on the first clock of each frame, aligned with the VSYNC leading edge.
- R11: With `enable_i`=0, the counters clear and, one clock later, every pin is inactive and the strobes are low. After re-enable, output starts with a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the counters |
| sync_en_i | input | 1 | Allow HSYNC/VSYNC to go active |
| h_period_i | input | H_W | Line length in clocks |
| h_sync_w_i | input | H_W | HSYNC width in clocks |
| h_wait_i | input | H_W | Clocks from HSYNC leading edge to first pixel |
| h_valid_i | input | H_W | Valid pixels per line |
| v_period_i | input | H_W+V_W | Frame length, in lines or clocks |
| v_sync_w_i | input | H_W+V_W | VSYNC width, in lines or clocks |
| v_wait_i | input | V_W | Lines from VSYNC leading edge to first active line |
| v_valid_i | input | V_W | Active lines per frame |
| v_unit_lines_i | input | 1 | 1: vertical width and period in lines; 0: in clocks |
| hs_high_i | input | 1 | HSYNC active-high |
| vs_high_i | input | 1 | VSYNC active-high |
| de_high_i | input | 1 | DE active-high |
| clk_fall_i | input | 1 | Panel samples on falling edge |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pix_req_o | output | 1 | Active-high pixel request strobe |
| frame_start_o | output | 1 | One-cycle frame-start pulse |
| dclk_fall_o | output | 1 | Clock-edge select toward the clock path |

## Verification
The bench builds the block with its default widths, H_W = V_W = 12. It then programs small geometries through the ports, so a whole frame spans only tens to a few hundred clocks. That reach lets each phase cover several complete frames:
- A normal line-unit frame.
- Inverted polarities.
- Sync suppressed.
- A mid-frame disable followed by a restart.
- A clock-unit frame that ends in the middle of a line.
- The corner with zero waits and zero sync widths, where active data fills whole lines from the first clock.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int NPIN = 3;  // HSYNC, VSYNC, DE pins
  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } sig_set_t;
endpackage

// File: rtl/dtg_wrap_cnt.sv
module dtg_wrap_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic         wrap_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (adv_i)  cnt_o <= wrap_i ? '0 : cnt_o + W'(1);
  end

  // R11: a clear forces the count to zero on the next clock
  p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);
  // R1: an advance that is not a wrap steps the count by one
  p_adv_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && adv_i && !wrap_i) |=> cnt_o == $past(cnt_o) + W'(1));
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage
  import dtg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  logic     sync_en_i,
  input  sig_set_t act_i,
  input  sig_set_t high_i,
  input  logic     fs_i,
  input  logic     clk_fall_i,
  output logic     hsync_o,
  output logic     vsync_o,
  output logic     de_o,
  output logic     pix_req_o,
  output logic     frame_start_o,
  output logic     dclk_fall_o
);
  logic [NPIN-1:0] act_v, pol_v, gate_v, pin_v;

  assign act_v  = {act_i.de, act_i.vs, act_i.hs};
  assign pol_v  = {high_i.de, high_i.vs, high_i.hs};
  assign gate_v = {run_i, run_i & sync_en_i, run_i & sync_en_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b1;
      else        q <= ~((act_v[g] & gate_v[g]) ^ pol_v[g]);
    end
    assign pin_v[g] = q;
  end

  assign hsync_o = pin_v[0];
  assign vsync_o = pin_v[1];
  assign de_o    = pin_v[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_req_o     <= 1'b0;
      frame_start_o <= 1'b0;
      dclk_fall_o   <= 1'b0;
    end else begin
      pix_req_o     <= run_i & act_i.de;
      frame_start_o <= run_i & fs_i;
      dclk_fall_o   <= run_i & clk_fall_i;
    end
  end

  // R11: stopped run leaves both strobes low
  p_idle_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pix_req_o && !frame_start_o);
  // R9: sync suppressed keeps both sync pins at their inactive level
  p_sync_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en_i |=> (hsync_o == !$past(high_i.hs)) && (vsync_o == !$past(high_i.vs)));
  // R5: request strobe and DE pin agree, DE in its programmed polarity
  p_req_de_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && act_i.de) |=> pix_req_o && (de_o == $past(high_i.de)));
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               sync_en_i,
  input  logic [H_W-1:0]     h_period_i,
  input  logic [H_W-1:0]     h_sync_w_i,
  input  logic [H_W-1:0]     h_wait_i,
  input  logic [H_W-1:0]     h_valid_i,
  input  logic [H_W+V_W-1:0] v_period_i,
  input  logic [H_W+V_W-1:0] v_sync_w_i,
  input  logic [V_W-1:0]     v_wait_i,
  input  logic [V_W-1:0]     v_valid_i,
  input  logic               v_unit_lines_i,
  input  logic               hs_high_i,
  input  logic               vs_high_i,
  input  logic               de_high_i,
  input  logic               clk_fall_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pix_req_o,
  output logic               frame_start_o,
  output logic               dclk_fall_o
);
  localparam int F_W = H_W + V_W;

  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;
  logic [F_W-1:0] fcnt;
  logic h_last, frame_last, line_end;
  logic h_in, v_in;
  sig_set_t act, high;

  assign h_last     = (hcnt == h_period_i - H_W'(1));
  assign frame_last = v_unit_lines_i ? (h_last && (F_W'(vcnt) == v_period_i - F_W'(1)))
                                     : (fcnt == v_period_i - F_W'(1));
  assign line_end   = h_last || frame_last;

  dtg_wrap_cnt #(.W(H_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr_i(!enable_i), .adv_i(1'b1),
    .wrap_i(line_end), .cnt_o(hcnt));
  dtg_wrap_cnt #(.W(V_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr_i(!enable_i), .adv_i(line_end),
    .wrap_i(frame_last), .cnt_o(vcnt));
  dtg_wrap_cnt #(.W(F_W)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .clr_i(!enable_i), .adv_i(1'b1),
    .wrap_i(frame_last), .cnt_o(fcnt));

  assign h_in = (hcnt >= h_wait_i) &&
                ({1'b0, hcnt} < ({1'b0, h_wait_i} + {1'b0, h_valid_i}));
  assign v_in = (vcnt >= v_wait_i) &&
                ({1'b0, vcnt} < ({1'b0, v_wait_i} + {1'b0, v_valid_i}));

  assign act.hs  = (hcnt < h_sync_w_i);
  assign act.vs  = v_unit_lines_i ? (F_W'(vcnt) < v_sync_w_i) : (fcnt < v_sync_w_i);
  assign act.de  = h_in && v_in;
  assign high.hs = hs_high_i;
  assign high.vs = vs_high_i;
  assign high.de = de_high_i;

  dtg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .run_i(enable_i), .sync_en_i(sync_en_i),
    .act_i(act), .high_i(high),
    .fs_i((hcnt == '0) && (vcnt == '0) && (fcnt == '0)),
    .clk_fall_i(clk_fall_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .frame_start_o(frame_start_o), .dclk_fall_o(dclk_fall_o));

  // R10: a frame start with sync enabled and nonzero width shows active VSYNC
  p_fs_vsync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && sync_en_i && v_sync_w_i != '0 && hcnt == '0 && vcnt == '0 && fcnt == '0)
      |=> frame_start_o && (vsync_o == $past(vs_high_i)));
  // R1: the line counter never passes the last position of the line
  p_h_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && h_last) |=> hcnt == '0);
endmodule

// File: tb/dtg_top_bench.sv
`timescale 1ns/1ps
module dtg_top_bench;
  localparam int H_W = 12;
  localparam int V_W = 12;
  localparam int F_W = H_W + V_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0, sync_en_i = 1'b0, v_unit_lines_i = 1'b1;
  logic hs_high_i = 1'b0, vs_high_i = 1'b0, de_high_i = 1'b0, clk_fall_i = 1'b0;
  logic [H_W-1:0] h_period_i = 12'd10, h_sync_w_i = 12'd2, h_wait_i = 12'd4, h_valid_i = 12'd4;
  logic [F_W-1:0] v_period_i = 24'd8, v_sync_w_i = 24'd1;
  logic [V_W-1:0] v_wait_i = 12'd3, v_valid_i = 12'd3;
  logic hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, dclk_fall_o;

  dtg_top #(.H_W(H_W), .V_W(V_W)) u_dtg_top (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sync_en_i(sync_en_i),
    .h_period_i(h_period_i), .h_sync_w_i(h_sync_w_i), .h_wait_i(h_wait_i),
    .h_valid_i(h_valid_i), .v_period_i(v_period_i), .v_sync_w_i(v_sync_w_i),
    .v_wait_i(v_wait_i), .v_valid_i(v_valid_i), .v_unit_lines_i(v_unit_lines_i),
    .hs_high_i(hs_high_i), .vs_high_i(vs_high_i), .de_high_i(de_high_i),
    .clk_fall_i(clk_fall_i), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .frame_start_o(frame_start_o), .dclk_fall_o(dclk_fall_o));

  always #2.5 clk = ~clk;  // 200 MHz

  int n_vec = 0, n_bad = 0;
  string tag = "R11";
  int mh = 0, mv = 0, mf = 0;
  logic e_hs = 1'b1, e_vs = 1'b1, e_de = 1'b1, e_req = 1'b0, e_fs = 1'b0, e_dclk = 1'b0;

  // Behavioural reference: raster position as plain integers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mf = 0;
      e_hs = 1; e_vs = 1; e_de = 1; e_req = 0; e_fs = 0; e_dclk = 0;
    end else if (!enable_i) begin
      mh = 0; mv = 0; mf = 0;
      e_hs = !hs_high_i; e_vs = !vs_high_i; e_de = !de_high_i;
      e_req = 0; e_fs = 0; e_dclk = 0;
    end else begin
      int hp, vp;
      bit a_hs, a_vs, a_de, hw, fw;
      hp = int'(h_period_i); vp = int'(v_period_i);
      a_hs = sync_en_i && (mh < int'(h_sync_w_i));
      a_vs = sync_en_i && ((v_unit_lines_i ? mv : mf) < int'(v_sync_w_i));
      a_de = (mh >= int'(h_wait_i)) && (mh < int'(h_wait_i) + int'(h_valid_i)) &&
             (mv >= int'(v_wait_i)) && (mv < int'(v_wait_i) + int'(v_valid_i));
      e_hs = hs_high_i ? a_hs : !a_hs;
      e_vs = vs_high_i ? a_vs : !a_vs;
      e_de = de_high_i ? a_de : !a_de;
      e_req = a_de;
      e_fs = (mh == 0 && mv == 0 && mf == 0);
      e_dclk = clk_fall_i;
      hw = (mh == hp - 1);
      fw = v_unit_lines_i ? (hw && mv == vp - 1) : (mf == vp - 1);
      mf = fw ? 0 : mf + 1;
      if (fw) mv = 0; else if (hw) mv = mv + 1;
      mh = (hw || fw) ? 0 : mh + 1;
    end
  end

  task automatic cmp(string req, string nm, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s at %0t: actual %b expected %b", tag, req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("R2", "hsync", hsync_o, e_hs);
    cmp(v_unit_lines_i ? "R6" : "R7", "vsync", vsync_o, e_vs);
    cmp("R3", "de", de_o, e_de);
    cmp("R5", "pix_req", pix_req_o, e_req);
    cmp("R10", "frame_start", frame_start_o, e_fs);
    cmp("R8", "dclk_fall", dclk_fall_o, e_dclk);
  end

  task automatic idle(int n);
    enable_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run(int n);
    enable_i = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state, R11
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 R2 R3 R4 R6 R10: normal line-unit frames (80 clocks each)
    tag = "R1"; sync_en_i = 1'b1;
    run(170);
    // R8: all polarities active-high, falling clock edge
    idle(2); tag = "R8";
    hs_high_i = 1; vs_high_i = 1; de_high_i = 1; clk_fall_i = 1;
    run(90);
    // R9: sync suppressed, DE keeps running
    idle(2); tag = "R9"; sync_en_i = 1'b0;
    run(90);
    // R11: stop mid-frame, restart from a fresh frame
    tag = "R11"; sync_en_i = 1'b1; hs_high_i = 0; vs_high_i = 0; de_high_i = 0; clk_fall_i = 0;
    idle(2); run(37); idle(5); run(60);
    // R7: clock-unit frame of 25 clocks, ends mid-line
    idle(2); tag = "R7";
    v_unit_lines_i = 1'b0; v_period_i = 24'd25; v_sync_w_i = 24'd7;
    run(90);
    // R4: zero waits, zero sync widths, full-width active lines
    idle(2); tag = "R4";
    v_unit_lines_i = 1'b1; v_period_i = 24'd8; v_sync_w_i = 24'd0;
    h_sync_w_i = 12'd0; h_wait_i = 12'd0; h_valid_i = 12'd10;
    v_wait_i = 12'd0; v_valid_i = 12'd8;
    run(90);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule